// File: doc/BRIEF.md
# Serial Port Wake-Up Event Controller

This block watches the four modem-status inputs and the serial receive line of one UART channel. It raises a power-management wake request while the function sits in a reduced-power state. Host configuration logic sets three things through single-cycle strobes: the device power state, the wake enable bit, and the write-one-to-clear status bit. A level input loaded at reset from non-volatile settings can veto wake generation altogether.

Which lines can wake the function depends on the power state. In D3 only the ring-indicate line counts. In D2 a change on any modem line counts, and so does a start bit (a falling edge) on the receive line. In D0 nothing counts. A bus-mode input picks the output pin. In PCI mode the request appears on an open-drain, active-low wake pin. In cardbus mode it appears on an active-high status-change pin. Every line input passes through a two-flop synchroniser before the block looks for changes.

Top module: `serial_wake_ctrl`

## Requirements
- R1: After reset, `pme_status` is 0, `pme_enable` is 0, `power_state` is 2'b00 (D0), `csyschg` is 0 and `pme_n` is released (high-Z).
- R2: With `power_state` at 2'b00 (D0) or 2'b01 (D1), no change on any line input sets `pme_status`.
- R3: With `power_state` at 2'b11 (D3), a change of `ri` in either direction sets `pme_status`. Changes on `cts`, `dsr` or `dcd`, and any edge on `sin`, do not set it.
- R4: With `power_state` at 2'b10 (D2), a change in either direction on `cts`, `dsr`, `dcd` or `ri` sets `pme_status`, and so does a 1-to-0 transition of `sin`. A 0-to-1 transition of `sin` does not.
- R5: A qualifying line change driven before rising edge k is visible on `pme_status` and the pins after edge k+2, and not after edge k+1.
- R6: `pme_status` is sticky. It survives a return to D0 and clears only on reset or on a `cfg_sts_clr` pulse, which takes effect at the next edge. A qualifying event arriving at the same edge as the clear wins, and the status stays set.
- R7: The wake pins assert only while `pme_status`, `pme_enable` and `wake_allow` are all 1. `pme_enable` takes the value of `cfg_en_val` at an edge where `cfg_en_wr` is 1.
- R8: With `cardbus_mode` 0, a wake request drives `pme_n` low and holds `csyschg` at 0. With `cardbus_mode` 1, it drives `csyschg` high and leaves `pme_n` released.
- R9: While `wake_allow` is 0, qualifying events do not set `pme_status`, and both pins stay idle.
- R10: Line activity during the first three edges after reset, while the synchronisers prime, is not taken as an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pwr_wr | input | 1 | Power-state write strobe |
| cfg_pwr_val | input | 2 | Power state to write (00 D0, 01 D1, 10 D2, 11 D3) |
| cfg_en_wr | input | 1 | Wake enable write strobe |
| cfg_en_val | input | 1 | Wake enable value to write |
| cfg_sts_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| wake_allow | input | 1 | Wake generation permitted (loaded at reset from settings) |
| cardbus_mode | input | 1 | 0 selects PCI pin, 1 selects cardbus pin |
| ri | input | 1 | Ring indicate line |
| dcd | input | 1 | Data carrier detect line |
| dsr | input | 1 | Data set ready line |
| cts | input | 1 | Clear to send line |
| sin | input | 1 | Serial data in |
| pme_n | output | 1 | Open-drain active-low wake request (PCI mode) |
| csyschg | output | 1 | Active-high status-change wake request (cardbus mode) |
| power_state | output | 2 | Current power state |
| pme_enable | output | 1 | Current wake enable bit |
| pme_status | output | 1 | Sticky wake status bit |

## Verification
A line change needs three rising edges before it shows on `pme_status`: two synchroniser stages and then the status register. The pins follow the status with no further delay. Each scenario task therefore drives a line at a falling edge, waits three rising edges, and samples at the next falling edge. The latency test also samples one edge earlier to confirm the status is still clear. Configuration strobes and the clear pulse act at the first rising edge and are checked at the falling edge that follows. Negative cases wait four edges before confirming that nothing was set.

// File: rtl/swk_pkg.sv
// Package: shared types and constants for the serial wake controller.
// Assumes: line vector order below is used by every submodule.
package swk_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    localparam int NLINES   = 5;
    localparam int L_RI     = 0;
    localparam int L_DCD    = 1;
    localparam int L_DSR    = 2;
    localparam int L_CTS    = 3;
    localparam int L_SIN    = 4;
    localparam int NMODEM   = 4;

endpackage

// File: rtl/swk_line_sync.sv
// Module: per-line multi-stage synchroniser plus a one-cycle history
// register, and a priming flag that holds off change detection until the
// chain and history hold real samples.
// Assumes: STAGES >= 2; raw inputs are asynchronous to clk.
module swk_line_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev,
    output logic         primed
);
    localparam int WARM = STAGES + 1;
    localparam int CW   = $clog2(WARM + 1);

    logic [CW-1:0] warm_cnt;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] chain;
        // Purpose: shift the raw line through the synchroniser flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign cur[i] = chain[STAGES-1];
    end

    // Purpose: keep last cycle's synchronised value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    // Purpose: count edges after reset until the history is trustworthy.
    always_ff @(posedge clk) begin
        if (!rst_n)                          warm_cnt <= '0;
        else if (warm_cnt != WARM[CW-1:0])   warm_cnt <= warm_cnt + 1'b1;
    end

    assign primed = (warm_cnt == WARM[CW-1:0]);

endmodule

// File: rtl/swk_event_qual.sv
// Module: decides whether this cycle's line activity is a wake event for
// the current power state. Purely combinational.
// Assumes: cur/prev follow the swk_pkg line order.
module swk_event_qual
    import swk_pkg::*;
(
    input  pstate_e           pstate,
    input  logic [NLINES-1:0] cur,
    input  logic [NLINES-1:0] prev,
    input  logic              primed,
    input  logic              allow,
    output logic              evt
);
    logic [NLINES-1:0] chg;
    logic              sin_fall;
    logic              modem_chg;
    logic              raw_evt;

    assign chg       = cur ^ prev;
    assign sin_fall  = prev[L_SIN] & ~cur[L_SIN];
    assign modem_chg = |chg[NMODEM-1:0];

    // Purpose: select the wake sources permitted in each power state.
    always_comb begin
        unique case (pstate)
            PS_D3:   raw_evt = chg[L_RI];
            PS_D2:   raw_evt = modem_chg | sin_fall;
            default: raw_evt = 1'b0;
        endcase
    end

    assign evt = raw_evt & primed & allow;

endmodule

// File: rtl/swk_status_regs.sv
// Module: configuration-visible state: power state, wake enable and the
// sticky wake status bit.
// Assumes: strobes are single-cycle, synchronous to clk.
module swk_status_regs
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_wr,
    input  logic [1:0] pwr_val,
    input  logic       en_wr,
    input  logic       en_val,
    input  logic       sts_clr,
    input  logic       evt,
    output pstate_e    pstate,
    output logic       en,
    output logic       sts
);
    // Purpose: hold the power state written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)      pstate <= PS_D0;
        else if (pwr_wr) pstate <= pstate_e'(pwr_val);
    end

    // Purpose: hold the wake enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= 1'b0;
        else if (en_wr) en <= en_val;
    end

    // Purpose: sticky status; a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts <= 1'b0;
        else if (evt)     sts <= 1'b1;
        else if (sts_clr) sts <= 1'b0;
    end

endmodule

// File: rtl/swk_pin_drive.sv
// Module: routes the gated wake request to the pin of the selected bus mode.
// Assumes: the open-drain release is done at the top level.
module swk_pin_drive (
    input  logic sts,
    input  logic en,
    input  logic allow,
    input  logic cardbus,
    output logic pme_low,
    output logic csyschg
);
    logic req;

    assign req     = sts & en & allow;
    assign pme_low = req & ~cardbus;
    assign csyschg = req &  cardbus;

endmodule

// File: rtl/serial_wake_ctrl.sv
// Module: top of the serial-port wake controller. Synchronises the line
// inputs, qualifies events by power state, keeps the sticky status and
// drives the mode-selected wake pin.
// Assumes: pme_n has an external pull-up; it is only ever driven low.
module serial_wake_ctrl
    import swk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_pwr_wr,
    input  logic [1:0] cfg_pwr_val,
    input  logic       cfg_en_wr,
    input  logic       cfg_en_val,
    input  logic       cfg_sts_clr,
    input  logic       wake_allow,
    input  logic       cardbus_mode,
    input  logic       ri,
    input  logic       dcd,
    input  logic       dsr,
    input  logic       cts,
    input  logic       sin,
    output wire        pme_n,
    output logic       csyschg,
    output logic [1:0] power_state,
    output logic       pme_enable,
    output logic       pme_status
);
    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] cur_lines;
    logic [NLINES-1:0] prev_lines;
    logic              primed;
    logic              evt;
    pstate_e           pstate;
    logic              pme_low;

    // Purpose: pack the line inputs in package order.
    always_comb begin
        raw_lines        = '0;
        raw_lines[L_RI]  = ri;
        raw_lines[L_DCD] = dcd;
        raw_lines[L_DSR] = dsr;
        raw_lines[L_CTS] = cts;
        raw_lines[L_SIN] = sin;
    end

    swk_line_sync #(.N(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_lines),
        .cur    (cur_lines),
        .prev   (prev_lines),
        .primed (primed)
    );

    swk_event_qual u_qual (
        .pstate (pstate),
        .cur    (cur_lines),
        .prev   (prev_lines),
        .primed (primed),
        .allow  (wake_allow),
        .evt    (evt)
    );

    swk_status_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_wr  (cfg_pwr_wr),
        .pwr_val (cfg_pwr_val),
        .en_wr   (cfg_en_wr),
        .en_val  (cfg_en_val),
        .sts_clr (cfg_sts_clr),
        .evt     (evt),
        .pstate  (pstate),
        .en      (pme_enable),
        .sts     (pme_status)
    );

    swk_pin_drive u_pins (
        .sts     (pme_status),
        .en      (pme_enable),
        .allow   (wake_allow),
        .cardbus (cardbus_mode),
        .pme_low (pme_low),
        .csyschg (csyschg)
    );

    assign power_state = pstate;
    assign pme_n       = pme_low ? 1'b0 : 1'bz;

endmodule

// File: rtl/swk_checker.sv
// Module: temporal checks on the wake controller's ports, bound to the top.
module swk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_sts_clr,
    input logic       wake_allow,
    input logic       cardbus_mode,
    input logic       csyschg,
    input logic [1:0] power_state,
    input logic       pme_enable,
    input logic       pme_status
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pme_status && !pme_enable && power_state == 2'b00));

    assert_d0_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_status) |-> $past(power_state[1]));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_status && !cfg_sts_clr) |=> pme_status);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_sts_clr) && !$past(power_state[1])) |-> !pme_status);

    assert_cb_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        csyschg |-> (cardbus_mode && pme_status && pme_enable && wake_allow));

    assert_no_allow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_status) |-> $past(wake_allow));

endmodule

bind serial_wake_ctrl swk_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sts_clr  (cfg_sts_clr),
    .wake_allow   (wake_allow),
    .cardbus_mode (cardbus_mode),
    .csyschg      (csyschg),
    .power_state  (power_state),
    .pme_enable   (pme_enable),
    .pme_status   (pme_status)
);

// File: tb/serial_wake_ctrl_tb.sv
// Directed bench for serial_wake_ctrl; each task drives one scenario.
module serial_wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_pwr_wr, cfg_en_wr, cfg_en_val, cfg_sts_clr;
    logic [1:0] cfg_pwr_val;
    logic       wake_allow, cardbus_mode;
    logic       ri, dcd, dsr, cts, sin;
    wire        pme_n;
    logic       csyschg;
    logic [1:0] power_state;
    logic       pme_enable, pme_status;

    int checks = 0;
    int fails  = 0;

    pullup (pme_n);

    always #2.5 clk = ~clk;

    serial_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pwr_wr(cfg_pwr_wr), .cfg_pwr_val(cfg_pwr_val),
        .cfg_en_wr(cfg_en_wr), .cfg_en_val(cfg_en_val),
        .cfg_sts_clr(cfg_sts_clr), .wake_allow(wake_allow),
        .cardbus_mode(cardbus_mode),
        .ri(ri), .dcd(dcd), .dsr(dsr), .cts(cts), .sin(sin),
        .pme_n(pme_n), .csyschg(csyschg), .power_state(power_state),
        .pme_enable(pme_enable), .pme_status(pme_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pwr_wr = 0; cfg_pwr_val = 0; cfg_en_wr = 0; cfg_en_val = 0;
        cfg_sts_clr = 0; wake_allow = 1; cardbus_mode = 0;
        ri = 0; dcd = 0; dsr = 0; cts = 0; sin = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic set_pwr(input logic [1:0] v);
        cfg_pwr_wr = 1; cfg_pwr_val = v;
        @(negedge clk);
        cfg_pwr_wr = 0;
    endtask

    task automatic set_en(input logic v);
        cfg_en_wr = 1; cfg_en_val = v;
        @(negedge clk);
        cfg_en_wr = 0;
    endtask

    task automatic clear_sts();
        cfg_sts_clr = 1;
        @(negedge clk);
        cfg_sts_clr = 0;
    endtask

    // Wait for a positive result: three rising edges, sample at next fall.
    task automatic settle_hit();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_miss();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 status", pme_status, 0);
        check("R1 enable", pme_enable, 0);
        check("R1 pstate", power_state, 2'b00);
        check("R1 csyschg", csyschg, 0);
        check("R1 pme_n released", pme_n, 1);
    endtask

    task automatic t_d0_quiet();
        do_reset();
        set_en(1);
        cts = 1; dsr = 1; dcd = 1; ri = 1; sin = 0;
        settle_miss();
        check("R2 D0 no wake", pme_status, 0);
        set_pwr(2'b01);
        cts = 0; dsr = 0; dcd = 0; ri = 0; sin = 1;
        settle_miss();
        sin = 0;
        settle_miss();
        check("R2 D1 no wake", pme_status, 0);
        check("R2 pin idle", pme_n, 1);
    endtask

    task automatic t_d3();
        do_reset();
        set_en(1);
        set_pwr(2'b11);
        cts = 1; dsr = 1; dcd = 1;
        settle_miss();
        check("R3 modem ignored in D3", pme_status, 0);
        sin = 0;
        settle_miss();
        check("R3 sin ignored in D3", pme_status, 0);
        ri = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 not yet after two edges", pme_status, 0);
        @(posedge clk);
        @(negedge clk);
        check("R5 set after third edge", pme_status, 1);
        check("R3 ri rise wakes", pme_n, 0);
        clear_sts();
        check("R6 clear at next edge", pme_status, 0);
        ri = 0;
        settle_hit();
        check("R3 ri fall wakes", pme_status, 1);
        clear_sts();
    endtask

    task automatic t_d2();
        do_reset();
        set_en(1);
        set_pwr(2'b10);
        cts = 1; settle_hit(); check("R4 cts", pme_status, 1); clear_sts();
        dsr = 1; settle_hit(); check("R4 dsr", pme_status, 1); clear_sts();
        dcd = 1; settle_hit(); check("R4 dcd", pme_status, 1); clear_sts();
        ri = 1;  settle_hit(); check("R4 ri", pme_status, 1);  clear_sts();
        cts = 0; settle_hit(); check("R4 cts fall", pme_status, 1); clear_sts();
        sin = 0; settle_hit(); check("R4 sin start bit", pme_status, 1); clear_sts();
        sin = 1; settle_miss(); check("R4 sin rise ignored", pme_status, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        set_en(1);
        set_pwr(2'b10);
        dsr = 1;
        settle_hit();
        set_pwr(2'b00);
        repeat (6) @(negedge clk);
        check("R6 survives D0", pme_status, 1);
        set_pwr(2'b10);
        repeat (3) @(negedge clk);
        // event lands at the same edge as the clear
        dcd = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cfg_sts_clr = 1;
        @(negedge clk);
        cfg_sts_clr = 0;
        check("R6 event beats clear", pme_status, 1);
        clear_sts();
        check("R6 clear alone", pme_status, 0);
    endtask

    task automatic t_enable();
        do_reset();
        set_pwr(2'b10);
        check("R7 enable default off", pme_enable, 0);
        cts = 1;
        settle_hit();
        check("R7 status set without enable", pme_status, 1);
        check("R7 pin idle without enable", pme_n, 1);
        set_en(1);
        check("R7 enable written", pme_enable, 1);
        check("R7 pin asserted", pme_n, 0);
        set_en(0);
        check("R7 pin released on disable", pme_n, 1);
        clear_sts();
    endtask

    task automatic t_routing();
        do_reset();
        cardbus_mode = 1;
        set_en(1);
        set_pwr(2'b11);
        ri = 1;
        settle_hit();
        check("R8 cardbus csyschg high", csyschg, 1);
        check("R8 cardbus pme_n released", pme_n, 1);
        cardbus_mode = 0;
        @(negedge clk);
        check("R8 pci pme_n low", pme_n, 0);
        check("R8 pci csyschg low", csyschg, 0);
        clear_sts();
        check("R8 pme_n released after clear", pme_n, 1);
    endtask

    task automatic t_allow();
        do_reset();
        wake_allow = 0;
        set_en(1);
        set_pwr(2'b10);
        cts = 1; sin = 0;
        settle_miss();
        check("R9 no status when disallowed", pme_status, 0);
        check("R9 pme_n idle", pme_n, 1);
        check("R9 csyschg idle", csyschg, 0);
        wake_allow = 1;
    endtask

    task automatic t_warmup();
        @(negedge clk);
        rst_n = 0;
        cfg_pwr_wr = 0; cfg_en_wr = 0; cfg_sts_clr = 0; wake_allow = 1;
        cardbus_mode = 0;
        ri = 1; dcd = 1; dsr = 1; cts = 1; sin = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cfg_pwr_wr = 1; cfg_pwr_val = 2'b10;
        @(negedge clk);
        cfg_pwr_wr = 0;
        repeat (6) @(negedge clk);
        check("R10 priming not an event", pme_status, 0);
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0;
        t_reset();
        t_d0_quiet();
        t_d3();
        t_d2();
        t_sticky();
        t_enable();
        t_routing();
        t_allow();
        t_warmup();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule